// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver with Two-Entry Buffer

This block receives asynchronous serial characters on a single line. A front end watches the line on every pulse of a tick that runs at sixteen times the bit rate. It waits for a falling edge and confirms the start bit at mid-bit. It then takes a three-sample majority vote at the centre of every later bit and shifts the result into a character register that advances once per bit. A character has eight data bits, or nine when the wide mode is selected. The stop position is checked, and the finished character goes into a small buffer. The character's ninth bit and its framing-error status are stored with it.

A host reads characters by pulsing a read strobe. The oldest entry is always shown on the read outputs. The buffer can hold two complete characters while a third is still arriving. If a character completes while the buffer is full, the block raises a sticky overrun flag and refuses further characters. The flag stays set until the receive enable is taken low. That clear also returns the receive state machine to idle, and the buffered characters are kept.

Top module: `oversamp_uart_rx`

## Requirements
- R1: After reset, `data_avail` and `overrun` are 0.
- R2: With `nine_bit`=0, a frame is received as one low start bit, 8 data bits sent least significant first, and a stop bit. The data appears on `rd_data`, and `rd_bit9` reads 0.
- R3: With `nine_bit`=1, a frame carries 9 data bits least significant first. The ninth bit received is presented on `rd_bit9`, and bits 0 to 7 are presented on `rd_data`.
- R4: Each bit is decided by a majority of three line samples, taken at oversample ticks 7, 8 and 9 counted from the bit's start (tick 0). A single-tick inversion at tick 8 of a data bit does not change the received value.
- R5: A falling edge whose line is high again by the mid-bit vote of the start bit is dropped without any error and without producing a character. The receiver then re-arms for the next falling edge.
- R6: The stop position is voted like a data bit. A low result sets `rd_ferr` for that character, and a high result leaves it 0.
- R7: The buffer holds two characters in arrival order. `data_avail` is 1 exactly when `rx_en` is 1 and at least one character is unread. A `rd_strobe` pulse removes the oldest entry, and a strobe while the buffer is empty has no effect.
- R8: Reception happens only while both `rx_en` and `port_en` are 1. A frame sent while `port_en` is 0 produces no character.
- R9: When a character completes while two characters are held, `overrun` becomes 1 and that character is discarded. While `overrun` is 1, no new character is stored, even after the buffer has been read.
- R10: Driving `rx_en` to 0 clears `overrun` and idles the receiver on the next clock. Characters already in the buffer are kept and become visible again when `rx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-clock pulse at sixteen times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable; low clears overrun |
| port_en | input | 1 | Port enable; reception needs it high |
| nine_bit | input | 1 | 1 selects 9 data bits per character |
| rd_strobe | input | 1 | One-clock pulse that pops the oldest character |
| rd_data | output | 8 | Data bits 0 to 7 of the oldest character |
| rd_bit9 | output | 1 | Ninth data bit of the oldest character |
| rd_ferr | output | 1 | Framing-error flag of the oldest character |
| data_avail | output | 1 | Unread character present and receiver enabled |
| overrun | output | 1 | Sticky overrun indication |

## Verification
The bench sweeps every 8-bit value and a spread of 9-bit values, so a bit-order or alignment slip shows up as a wrong `rd_data` or `rd_bit9`. A one-tick glitch at the centre sample of each data bit is sent. A receiver that sampled once instead of voting would return a corrupted byte. A short low pulse that recovers before mid-bit must yield nothing, and a design that skipped the start check would store a spurious character. The bench fills the buffer past capacity, checks that the overrun lockout persists through reads and that clearing the enable keeps stored data, and checks the stop-low framing flag and the port-enable gate.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/uart_rx_front.sv
module uart_rx_front
   import uart_rx_pkg::*;
#(
   parameter int OVS   = 16,
   parameter int DBITS = 8,
   parameter bit VOTE3 = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             line,
   input  logic             nine,
   output logic             done,
   output logic [DBITS:0]   word,
   output logic             ferr
);
   localparam int CW = $clog2(OVS);
   localparam int BW = $clog2(DBITS + 2);
   localparam logic [CW-1:0] T_A    = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] T_B    = CW'(OVS / 2);
   localparam logic [CW-1:0] T_C    = CW'(OVS / 2 + 1);
   localparam logic [CW-1:0] T_LAST = CW'(OVS - 1);
   localparam logic [BW-1:0] LAST8  = BW'(DBITS - 1);
   localparam logic [BW-1:0] LAST9  = BW'(DBITS);

   if (OVS < 8)    $error("uart_rx_front: OVS must be at least 8");
   if (DBITS < 2)  $error("uart_rx_front: DBITS must be at least 2");

   rx_state_e        state;
   logic [CW-1:0]    cnt;
   logic [BW-1:0]    bitn;
   logic [DBITS:0]   sr;
   logic             last, smp_a, smp_b, vote;

   if (VOTE3) begin : g_vote3
      assign vote = vote3(smp_a, smp_b, line);
   end else begin : g_vote1
      assign vote = smp_b;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RX_IDLE;
         cnt   <= '0;
         bitn  <= '0;
         sr    <= '0;
         last  <= 1'b1;
         smp_a <= 1'b1;
         smp_b <= 1'b1;
         done  <= 1'b0;
         word  <= '0;
         ferr  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!en) begin
            state <= RX_IDLE;
            cnt   <= '0;
            last  <= 1'b1;
         end else if (tick) begin
            last <= line;
            if (state == RX_IDLE) begin
               if (last && !line) begin
                  state <= RX_START;
                  cnt   <= CW'(1);
               end
            end else begin
               cnt <= (cnt == T_LAST) ? '0 : cnt + 1'b1;
               if (cnt == T_A) smp_a <= line;
               if (cnt == T_B) smp_b <= line;
               if (cnt == T_C) begin
                  unique case (state)
                     RX_START: begin
                        bitn  <= '0;
                        state <= vote ? RX_IDLE : RX_DATA;
                     end
                     RX_DATA: begin
                        sr   <= {vote, sr[DBITS:1]};
                        bitn <= bitn + 1'b1;
                        if (bitn == (nine ? LAST9 : LAST8)) state <= RX_STOP;
                     end
                     RX_STOP: begin
                        done  <= 1'b1;
                        ferr  <= ~vote;
                        word  <= nine ? sr : {1'b0, sr[DBITS:1]};
                        state <= RX_IDLE;
                     end
                     default: state <= RX_IDLE;
                  endcase
               end
            end
         end
      end
   end

   // R8: a disabled front end is idle one clock later
   p_idle_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> state == RX_IDLE);
   // R6: a completed character only follows a stop-position decision
   p_done_from_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(state) == RX_STOP);
   // R5: a new reception only starts on a tick
   p_start_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == RX_START) |-> $past(tick));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
   parameter int W     = 10,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         rd,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int NW = $clog2(DEPTH + 1);
   localparam logic [NW-1:0] NFULL = NW'(DEPTH);
   localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);

   if (DEPTH < 2) $error("uart_rx_fifo: DEPTH must be at least 2");

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [NW-1:0] num;

   assign empty = (num == '0);
   assign full  = (num == NFULL);
   assign rdata = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         num <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (wr) begin
            mem[wp] <= wdata;
            wp      <= (wp == PLAST) ? '0 : wp + 1'b1;
         end
         if (rd) rp <= (rp == PLAST) ? '0 : rp + 1'b1;
         if (wr && !rd)      num <= num + 1'b1;
         else if (rd && !wr) num <= num - 1'b1;
      end
   end

   // R7: the buffer is never written past capacity
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> (!full || rd));
   // R7: no pop of an empty buffer
   p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd |-> !empty);

endmodule

// File: rtl/oversamp_uart_rx.sv
module oversamp_uart_rx #(
   parameter int OVS   = 16,
   parameter int DBITS = 8,
   parameter int DEPTH = 2,
   parameter bit VOTE3 = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick16,
   input  logic             rxd,
   input  logic             rx_en,
   input  logic             port_en,
   input  logic             nine_bit,
   input  logic             rd_strobe,
   output logic [DBITS-1:0] rd_data,
   output logic             rd_bit9,
   output logic             rd_ferr,
   output logic             data_avail,
   output logic             overrun
);
   localparam int EW = DBITS + 2;

   logic            run, done, ferr, f_empty, f_full, full_now, wr, rd;
   logic [DBITS:0]  word;
   logic [EW-1:0]   head;

   assign run = rx_en & port_en & ~overrun;

   uart_rx_front #(.OVS(OVS), .DBITS(DBITS), .VOTE3(VOTE3)) i_front (
      .clk(clk), .rst_n(rst_n), .en(run), .tick(tick16), .line(rxd),
      .nine(nine_bit), .done(done), .word(word), .ferr(ferr)
   );

   assign rd       = rd_strobe & ~f_empty;
   assign full_now = f_full & ~rd;
   assign wr       = done & ~full_now;

   uart_rx_fifo #(.W(EW), .DEPTH(DEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n), .wr(wr), .wdata({ferr, word}), .rd(rd),
      .rdata(head), .empty(f_empty), .full(f_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               overrun <= 1'b0;
      else if (!rx_en)          overrun <= 1'b0;
      else if (done && full_now) overrun <= 1'b1;
   end

   assign rd_data    = head[DBITS-1:0];
   assign rd_bit9    = head[DBITS];
   assign rd_ferr    = head[DBITS+1];
   assign data_avail = rx_en & ~f_empty;

   // R9: overrun holds while the receiver stays enabled
   p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && rx_en) |=> overrun);
   // R9: nothing is stored during lockout
   p_ovr_locks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> !wr);
   // R10: a low enable clears overrun
   p_ovr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !overrun);

endmodule

// File: tb/test_oversamp_uart_rx.sv
module test_oversamp_uart_rx;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
   logic       rx_en = 1'b1, port_en = 1'b1, nine_bit = 1'b0, rd_strobe = 1'b0;
   logic [7:0] rd_data;
   logic       rd_bit9, rd_ferr, data_avail, overrun;
   int         n_chk = 0, n_err = 0;
   bit         ended = 1'b0;

   oversamp_uart_rx i_oversamp_uart_rx (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
      .port_en(port_en), .nine_bit(nine_bit), .rd_strobe(rd_strobe),
      .rd_data(rd_data), .rd_bit9(rd_bit9), .rd_ferr(rd_ferr),
      .data_avail(data_avail), .overrun(overrun)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   initial forever begin
      @(negedge clk);
      tick16 = ~tick16;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   task automatic wait_tick();
      do @(posedge clk); while (!tick16);
      #1;
   endtask

   task automatic hold(input logic v, input int n);
      for (int t = 0; t < n; t++) begin
         rxd = v;
         wait_tick();
      end
   endtask

   task automatic send(input logic [8:0] d, input logic nine, input logic stopv,
                       input int glitch_bit);
      int nb;
      nb = nine ? 9 : 8;
      hold(1'b1, 4);
      hold(1'b0, 16);
      for (int b = 0; b < nb; b++)
         for (int t = 0; t < 16; t++) begin
            rxd = (b == glitch_bit && t == 8) ? ~d[b] : d[b];
            wait_tick();
         end
      hold(stopv, 16);
      hold(1'b1, 2);
      @(negedge clk);
   endtask

   task automatic pop();
      @(negedge clk) rd_strobe = 1'b1;
      @(negedge clk) rd_strobe = 1'b0;
   endtask

   task automatic expect_char(input string req, input int d, input int b9, input int fe);
      chk(req, int'(data_avail), 1);
      chk(req, int'(rd_data), d);
      chk(req, int'(rd_bit9), b9);
      chk(req, int'(rd_ferr), fe);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 avail", int'(data_avail), 0);
      chk("R1 overrun", int'(overrun), 0);
      rst_n = 1'b1;

      // R2 full 8-bit sweep
      for (int v = 0; v < 256; v++) begin
         send(9'(v), 1'b0, 1'b1, -1);
         expect_char("R2", v, 0, 0);
         pop();
         chk("R2 popped", int'(data_avail), 0);
      end

      // R3 9-bit values
      nine_bit = 1'b1;
      for (int v = 0; v < 512; v += 9) begin
         send(9'(v), 1'b1, 1'b1, -1);
         expect_char("R3", v & 255, v >> 8, 0);
         pop();
      end
      send(9'h1FF, 1'b1, 1'b1, -1);
      expect_char("R3 max", 255, 1, 0);
      pop();
      nine_bit = 1'b0;

      // R4 centre glitch in each data bit
      for (int b = 0; b < 8; b++) begin
         send(9'h0A5, 1'b0, 1'b1, b);
         expect_char("R4", 8'hA5, 0, 0);
         pop();
      end

      // R5 false start, then a good frame
      hold(1'b1, 4);
      hold(1'b0, 3);
      hold(1'b1, 20);
      @(negedge clk);
      chk("R5 no char", int'(data_avail), 0);
      send(9'h03C, 1'b0, 1'b1, -1);
      expect_char("R5 rearm", 8'h3C, 0, 0);
      pop();

      // R6 framing error and its clearing
      send(9'h081, 1'b0, 1'b0, -1);
      expect_char("R6 low stop", 8'h81, 0, 1);
      pop();
      send(9'h07E, 1'b0, 1'b1, -1);
      expect_char("R6 high stop", 8'h7E, 0, 0);
      pop();

      // R8 port disabled
      port_en = 1'b0;
      send(9'h055, 1'b0, 1'b1, -1);
      chk("R8 no char", int'(data_avail), 0);
      port_en = 1'b1;

      // R7 ordering, pop on empty
      send(9'h011, 1'b0, 1'b1, -1);
      send(9'h022, 1'b0, 1'b1, -1);
      expect_char("R7 first", 8'h11, 0, 0);
      pop();
      expect_char("R7 second", 8'h22, 0, 0);
      pop();
      chk("R7 empty", int'(data_avail), 0);
      pop();
      send(9'h033, 1'b0, 1'b1, -1);
      expect_char("R7 after empty pop", 8'h33, 0, 0);
      pop();

      // R9 overrun
      send(9'h0C1, 1'b0, 1'b1, -1);
      send(9'h0C2, 1'b0, 1'b1, -1);
      chk("R9 pre", int'(overrun), 0);
      send(9'h0C3, 1'b0, 1'b1, -1);
      chk("R9 set", int'(overrun), 1);
      expect_char("R9 keep first", 8'hC1, 0, 0);
      pop();
      expect_char("R9 keep second", 8'hC2, 0, 0);
      send(9'h0C4, 1'b0, 1'b1, -1);
      expect_char("R9 locked", 8'hC2, 0, 0);
      chk("R9 still set", int'(overrun), 1);

      // R10 clear by enable, buffer kept
      @(negedge clk) rx_en = 1'b0;
      @(negedge clk);
      chk("R10 cleared", int'(overrun), 0);
      chk("R7 avail gated", int'(data_avail), 0);
      rx_en = 1'b1;
      @(negedge clk);
      expect_char("R10 kept", 8'hC2, 0, 0);
      pop();
      chk("R10 empty", int'(data_avail), 0);
      send(9'h05A, 1'b0, 1'b1, -1);
      expect_char("R10 resumes", 8'h5A, 0, 0);
      pop();

      finish_run();
   end
endmodule